// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a small 32-bit processor that completes one instruction every clock cycle. It holds its own instruction memory, data memory and a 32-entry register file. Combinational logic fetches, decodes, executes, accesses memory and writes back in a single cycle, so every architectural update lands on one rising edge.

It executes six instructions: register add and subtract, OR with a zero-extended immediate, load word, store word and branch-if-equal. The only inputs are the clock and a synchronous reset. A set of debug outputs shows the program counter and every register-file write. Software is placed in the instruction memory before reset is released. Results are observed through the debug write port, and data memory is observed by loading values back into registers.

Top module: `ls_core`

## Requirements
- R1: While `rst` is high, the PC is held at 0, no register or data-memory write occurs and `dbg_wr_en` is 0. After release, execution starts at address 0.
- R2: An R-type word (opcode 6'h00, fields rs[25:21], rt[20:16], rd[15:11]) with funct 6'h20 writes rs+rt to rd, and with funct 6'h22 writes rs−rt to rd (32-bit wrap-around). The PC then advances by 4.
- R3: OR-immediate (opcode 6'h0D, imm[15:0]) writes rs OR zero-extended imm to rt.
- R4: Load word (opcode 6'h23) writes to rt the data-memory word at byte address rs + sign-extended imm. The word index is taken from the address bits above bit 1.
- R5: Store word (opcode 6'h2B) writes rt to the data-memory word at rs + sign-extended imm and performs no register write.
- R6: Branch-if-equal (opcode 6'h04) sets the next PC to PC+4+(sign-extended imm × 4) when rs equals rt, and to PC+4 otherwise. It performs no register or memory write.
- R7: Register 0 always reads as zero. A write to it is dropped and is not reported on the debug port.
- R8: Any other opcode, and an R-type word with any other funct, acts as a no-op: no write of any kind, and the PC advances by 4.
- R9: `dbg_pc` is the address of the instruction executing in the current cycle. `dbg_wr_en`/`dbg_wr_addr`/`dbg_wr_data` show, one cycle later, the register write committed by the previous instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| dbg_pc | output | 32 | Address of the instruction executing now |
| dbg_wr_en | output | 1 | A register write was committed on the previous edge |
| dbg_wr_addr | output | 5 | Register index of that write |
| dbg_wr_data | output | 32 | Value of that write |

## Verification
The embedded properties check the following on every cycle: PC sequencing for non-branch words, the taken-branch target, the zero upper half of the OR-immediate operand, the absence of a register write during stores, reset clearing, and that register 0 never appears on the debug port. Only the bench's program can show that arithmetic, sign extension of load and store offsets, the memory round trip, the not-taken branch path and the no-op handling of unknown opcodes and functs produce the right register values. It also shows re-execution from address 0 after a mid-run reset.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_BEQ   = 6'h04;
  localparam logic [5:0] OPC_ORI   = 6'h0D;
  localparam logic [5:0] OPC_LW    = 6'h23;
  localparam logic [5:0] OPC_SW    = 6'h2B;
  localparam logic [5:0] FN_ADD    = 6'h20;
  localparam logic [5:0] FN_SUB    = 6'h22;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_OR} alu_op_e;

  typedef struct packed {
    logic    dst_rd;   // 1: write index from rd, 0: from rt
    logic    rf_we;
    logic    src_imm;  // 1: second operand is the extended immediate
    logic    ext_sign; // 1: sign extend, 0: zero extend
    logic    wb_mem;   // 1: write back memory data
    logic    mem_we;
    logic    branch;
    alu_op_e alu;
  } ctrl_t;
endpackage

// File: rtl/lsc_decode.sv
module lsc_decode
  import lsc_pkg::*;
(
  input  logic [5:0] op,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '0;          // unknown words: no writes, sequential PC
    ctrl.alu = ALU_ADD;
    unique case (op)
      OPC_RTYPE: begin
        ctrl.dst_rd = 1'b1;
        if (funct == FN_ADD) begin
          ctrl.rf_we = 1'b1;
          ctrl.alu   = ALU_ADD;
        end else if (funct == FN_SUB) begin
          ctrl.rf_we = 1'b1;
          ctrl.alu   = ALU_SUB;
        end
      end
      OPC_ORI: begin
        ctrl.rf_we   = 1'b1;
        ctrl.src_imm = 1'b1;
        ctrl.alu     = ALU_OR;
      end
      OPC_LW: begin
        ctrl.rf_we    = 1'b1;
        ctrl.src_imm  = 1'b1;
        ctrl.ext_sign = 1'b1;
        ctrl.wb_mem   = 1'b1;
      end
      OPC_SW: begin
        ctrl.src_imm  = 1'b1;
        ctrl.ext_sign = 1'b1;
        ctrl.mem_we   = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.alu    = ALU_SUB;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/lsc_regfile.sv
module lsc_regfile #(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra,
  input  logic [AW-1:0] rb,
  output logic [W-1:0]  qa,
  output logic [W-1:0]  qb
);
  localparam int N = 1 << AW;
  logic [W-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (we && wa != '0) mem[wa] <= wd;
  end

  assign qa = (ra == '0) ? '0 : mem[ra];
  assign qb = (rb == '0) ? '0 : mem[rb];
endmodule

// File: rtl/lsc_alu.sv
module lsc_alu
  import lsc_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    unique case (op)
      ALU_SUB: y = a - b;
      ALU_OR:  y = a | b;
      default: y = a + b;
    endcase
  end
  assign zero = (y == '0);
endmodule

// File: rtl/lsc_ram.sv
module lsc_ram #(
  parameter int W     = 32,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/ls_core.sv
module ls_core
  import lsc_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int REG_AW     = 5,
  parameter int IMEM_DEPTH = 64,
  parameter int DMEM_DEPTH = 64
) (
  input  logic              clk,
  input  logic              rst,
  output logic [XLEN-1:0]   dbg_pc,
  output logic              dbg_wr_en,
  output logic [REG_AW-1:0] dbg_wr_addr,
  output logic [XLEN-1:0]   dbg_wr_data
);
  localparam int IAW = $clog2(IMEM_DEPTH);
  localparam int DAW = $clog2(DMEM_DEPTH);
  localparam int IMW = 16;

  logic [XLEN-1:0]   pc, instr, rs_val, rt_val, ext_imm, sext_imm;
  logic [XLEN-1:0]   alu_b, alu_y, dm_rdata, wb_data, pc_plus4, br_tgt, pc_next;
  logic [5:0]        op, funct;
  logic [REG_AW-1:0] f_rs, f_rt, f_rd, wa;
  logic [IMW-1:0]    imm;
  logic              zero, rf_we, dm_we;
  ctrl_t             ctrl;

  lsc_ram #(.W(XLEN), .DEPTH(IMEM_DEPTH)) u_imem (
    .clk(clk), .we(1'b0), .addr(pc[IAW+1:2]), .wdata('0), .rdata(instr));

  assign op    = instr[31:26];
  assign f_rs  = instr[25:21];
  assign f_rt  = instr[20:16];
  assign f_rd  = instr[15:11];
  assign funct = instr[5:0];
  assign imm   = instr[IMW-1:0];

  lsc_decode u_dec (.op(op), .funct(funct), .ctrl(ctrl));

  assign wa    = ctrl.dst_rd ? f_rd : f_rt;
  assign rf_we = ctrl.rf_we & ~rst;
  assign dm_we = ctrl.mem_we & ~rst;

  lsc_regfile #(.W(XLEN), .AW(REG_AW)) u_rf (
    .clk(clk), .we(rf_we), .wa(wa), .wd(wb_data),
    .ra(f_rs), .rb(f_rt), .qa(rs_val), .qb(rt_val));

  assign sext_imm = {{(XLEN-IMW){imm[IMW-1]}}, imm};
  assign ext_imm  = ctrl.ext_sign ? sext_imm : {{(XLEN-IMW){1'b0}}, imm};
  assign alu_b    = ctrl.src_imm ? ext_imm : rt_val;

  lsc_alu #(.W(XLEN)) u_alu (
    .op(ctrl.alu), .a(rs_val), .b(alu_b), .y(alu_y), .zero(zero));

  lsc_ram #(.W(XLEN), .DEPTH(DMEM_DEPTH)) u_dmem (
    .clk(clk), .we(dm_we), .addr(alu_y[DAW+1:2]), .wdata(rt_val), .rdata(dm_rdata));

  assign wb_data  = ctrl.wb_mem ? dm_rdata : alu_y;
  assign pc_plus4 = pc + XLEN'(4);
  assign br_tgt   = pc_plus4 + {sext_imm[XLEN-3:0], 2'b00};
  assign pc_next  = (ctrl.branch && zero) ? br_tgt : pc_plus4;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc          <= '0;
      dbg_wr_en   <= 1'b0;
      dbg_wr_addr <= '0;
      dbg_wr_data <= '0;
    end else begin
      pc          <= pc_next;
      dbg_wr_en   <= rf_we && (wa != '0);
      dbg_wr_addr <= wa;
      dbg_wr_data <= wb_data;
    end
  end

  assign dbg_pc = pc;

  logic unused_bits;
  assign unused_bits = ^{pc[XLEN-1:IAW+2], pc[1:0], alu_y[XLEN-1:DAW+2], alu_y[1:0], instr[10:6]};

  // R1: reset leaves PC at zero and the debug port idle
  p_reset_clear_r1: assert property (@(posedge clk) $past(rst) |-> (pc == '0 && !dbg_wr_en));
  // R6, R8: every non-branch word advances the PC by exactly 4
  p_seq_pc_r6: assert property (@(posedge clk) disable iff (rst)
    (op != OPC_BEQ) |=> (pc == $past(pc) + XLEN'(4)));
  // R6: equal operands on a branch land on the scaled-offset target
  p_br_taken_r6: assert property (@(posedge clk) disable iff (rst)
    (op == OPC_BEQ && rs_val == rt_val) |=>
    (pc == $past(pc) + XLEN'(4) + ($past(sext_imm) << 2)));
  // R3: OR-immediate operand has a clear upper half
  p_ori_zext_r3: assert property (@(posedge clk) disable iff (rst)
    (op == OPC_ORI) |-> (alu_b[XLEN-1:IMW] == '0));
  // R5: a store writes memory and never the register file
  p_store_only_mem_r5: assert property (@(posedge clk) disable iff (rst)
    (op == OPC_SW) |-> (dm_we && !rf_we));
  // R7: register 0 is never reported as written
  p_r0_silent_r7: assert property (@(posedge clk) disable iff (rst)
    dbg_wr_en |-> (dbg_wr_addr != '0));
endmodule

// File: tb/sim_ls_core.sv
`timescale 1ns/100ps
module sim_ls_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] dbg_pc;
  logic        dbg_wr_en;
  logic [4:0]  dbg_wr_addr;
  logic [31:0] dbg_wr_data;
  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2.5 clk = ~clk;

  ls_core u0 (.clk(clk), .rst(rst), .dbg_pc(dbg_pc), .dbg_wr_en(dbg_wr_en),
              .dbg_wr_addr(dbg_wr_addr), .dbg_wr_data(dbg_wr_data));

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  function automatic logic [31:0] prog(input int i);
    case (i)
      0:  return enc_i(6'h0D, 0, 1, 16'h00F0);
      1:  return enc_i(6'h0D, 0, 2, 16'h8005);
      2:  return enc_r(1, 2, 3, 6'h20);
      3:  return enc_r(1, 2, 4, 6'h22);
      4:  return enc_i(6'h2B, 0, 3, 16'h0008);
      5:  return enc_i(6'h2B, 1, 4, 16'hFFFC);
      6:  return enc_i(6'h23, 0, 5, 16'h0008);
      7:  return enc_i(6'h23, 1, 6, 16'hFFFC);
      8:  return enc_i(6'h0D, 0, 0, 16'h1234);
      9:  return enc_r(0, 0, 7, 6'h20);
      10: return enc_i(6'h04, 5, 3, 16'h0002);
      11: return enc_i(6'h0D, 0, 8, 16'h0001);
      12: return enc_i(6'h0D, 0, 8, 16'h0002);
      13: return enc_i(6'h04, 1, 2, 16'h0005);
      14: return 32'hFC00_0000;
      15: return enc_r(1, 2, 9, 6'h25);
      16: return enc_i(6'h0D, 0, 10, 16'h0055);
      17: return enc_i(6'h04, 0, 0, 16'hFFFF);
      default: return 32'h0;
    endcase
  endfunction

  // expected write for each instruction index: {en, addr, data}
  function automatic logic [37:0] exp_wr(input int i);
    case (i)
      0:  return {1'b1, 5'd1,  32'h0000_00F0};
      1:  return {1'b1, 5'd2,  32'h0000_8005};
      2:  return {1'b1, 5'd3,  32'h0000_80F5};
      3:  return {1'b1, 5'd4,  32'hFFFF_80EB};
      6:  return {1'b1, 5'd5,  32'h0000_80F5};
      7:  return {1'b1, 5'd6,  32'hFFFF_80EB};
      9:  return {1'b1, 5'd7,  32'h0000_0000};
      16: return {1'b1, 5'd10, 32'h0000_0055};
      default: return '0;
    endcase
  endfunction

  function automatic string tag_of(input int i);
    case (i)
      0, 1, 8: return (i == 8) ? "R7 write to r0" : "R3 ori";
      2, 3, 9: return "R2 add/sub";
      4, 5:    return "R5 store";
      6, 7:    return "R4 load";
      10, 13, 17: return "R6 branch";
      14, 15:  return "R8 no-op";
      default: return "R9 debug port";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic check_wr(input int idx);
    logic [37:0] e;
    e = exp_wr(idx);
    check({tag_of(idx), " wr_en"}, {31'd0, dbg_wr_en}, {31'd0, e[37]});
    if (e[37]) begin
      check({tag_of(idx), " wr_addr"}, {27'd0, dbg_wr_addr}, {27'd0, e[36:32]});
      check({tag_of(idx), " wr_data"}, dbg_wr_data, e[31:0]);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      fails++;
      $display("FAIL watchdog: got %0d cycles expected fewer than 5000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int seq [17] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 9, 10, 13, 14, 15, 16, 17, 17};
    for (int i = 0; i < 64; i++) u0.u_imem.mem[i] = prog(i);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: held in reset, instruction 0 visible but not committed
    check("R1 reset pc", dbg_pc, 32'h0);
    check("R1 reset wr_en", {31'd0, dbg_wr_en}, 32'h0);
    rst = 1'b0;
    check("R9 pc step 0", dbg_pc, 32'h0);
    for (int s = 1; s < 17; s++) begin
      @(negedge clk);
      check("R9 pc trace", dbg_pc, 32'(seq[s] * 4));
      check_wr(seq[s-1]);
    end
    @(negedge clk);
    check("R6 branch self-loop pc", dbg_pc, 32'd68);
    check_wr(17);
    // R1: mid-run reset returns to address 0 and re-runs the program
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run reset pc", dbg_pc, 32'h0);
    check("R1 mid-run reset wr_en", {31'd0, dbg_wr_en}, 32'h0);
    @(negedge clk);
    check("R1 reset blocks writes", {31'd0, dbg_wr_en}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 restart pc", dbg_pc, 32'h4);
    check_wr(0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule